// File: doc/BRIEF.md
# Handshake Registered Transceiver with Parity

This block joins two sides of a byte-wide link, called side A and side B, through a pair of holding registers, one for each direction. The forward register takes a byte from side A and offers it to side B together with a generated parity bit. The return register takes a byte from side B together with the parity bit that came with it, and offers the byte to side A together with a parity check result. Each direction has a load strobe, a read enable and a full flag, so the sender and receiver can run a demand-response exchange. The sender loads the register, which sets the flag. The receiver reads by holding the enable active, and it clears the flag when it lets the enable go idle again.

All strobes and enables are active low and are sampled on one system clock. Instead of a real high-impedance state, each output is a value plus a drive-enable bit. The value is forced to zero whenever the drive enable is off, so the outputs can be wired straight into an on-chip bus multiplexer.

Top module: `xcvr_handshake_port`

## Requirements
- R1: Each direction's register captures its input byte on a rising clock edge when that direction's active-low load strobe is 0. When the strobe is 1 the register keeps its contents.
- R2: The edge that loads a direction's register also sets that direction's full flag to 1.
- R3: A full flag is cleared by the first clock edge after that direction's active-low read enable goes from 0 to 1. A read enable that is simply held at 0 or held at 1 leaves the flag unchanged.
- R4: While a read enable is 1, the matching data output has drive enable 0 and value 0. While it is 0, the drive enable is 1 and the value is the stored byte.
- R5: The generated parity output is driven only while the B-side read enable is 0. Its value is 1 when the stored forward byte has an even number of ones (including zero ones) and 0 when the count is odd. Otherwise its value is 0 with drive enable 0.
- R6: The edge that loads the return register also stores the incoming parity bit in a one-bit register. The error output uses the stored bit, not the live input.
- R7: While the A-side read enable is 0, the error output is 1 when the stored return byte plus the stored parity bit hold an odd number of ones, and 0 (error) when the count is even.
- R8: While the A-side read enable is 1, the error output is 1.
- R9: If a load and a flag-clearing enable edge hit the same clock edge, the flag ends up at 1.
- R10: A synchronous active-high reset clears both registers, the stored parity bit and both flags, and it treats both read enables as previously idle (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 8 | Byte presented by side A |
| bIn | input | 8 | Byte presented by side B |
| bParIn | input | 1 | Parity bit accompanying bIn |
| abLoadN | input | 1 | Load strobe of the forward register, active low |
| baLoadN | input | 1 | Load strobe of the return register, active low |
| abOeN | input | 1 | B-side read enable, active low; its rising edge clears abFull |
| baOeN | input | 1 | A-side read enable, active low; its rising edge clears baFull |
| bOut | output | 8 | Forward byte toward side B (0 when not driven) |
| bOutEn | output | 1 | Drive enable for bOut |
| parOut | output | 1 | Generated parity toward side B (0 when not driven) |
| parOutEn | output | 1 | Drive enable for parOut |
| aOut | output | 8 | Return byte toward side A (0 when not driven) |
| aOutEn | output | 1 | Drive enable for aOut |
| parErrN | output | 1 | Parity check result, 0 means error |
| abFull | output | 1 | Forward register holds unread data |
| baFull | output | 1 | Return register holds unread data |

## Verification
A wrong register or stored parity bit cannot be seen while the matching read enable is idle. It shows up as soon as that enable goes low: the data value, the generated parity or the error output are wrong in the same cycle, with no clock edge in between. A flag in the wrong state, or a wrong copy of an enable's previous value, shows on a full flag one edge after the load or the release that should have changed it. A spurious clear shows when an enable is held steady, and a missed clear shows when it is released. The bench therefore reads each output combinationally within the cycle the enable changes, and reads each flag just after the edge that should move it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NumDirs = 2;
  localparam int DirAB = 0;
  localparam int DirBA = 1;

  typedef struct packed {
    logic abLoad;
    logic baLoad;
    logic abDrive;
    logic baDrive;
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         abLoadN,
  input  logic         baLoadN,
  input  logic         abOeN,
  input  logic         baOeN,
  output xcvrStrobes_t strobes,
  output logic         abFull,
  output logic         baFull
);
  logic [NumDirs-1:0] loadReq;
  logic [NumDirs-1:0] oeIdle;
  logic [NumDirs-1:0] oePrev;
  logic [NumDirs-1:0] oeRise;
  logic [NumDirs-1:0] full;

  assign loadReq[DirAB] = ~abLoadN;
  assign loadReq[DirBA] = ~baLoadN;
  assign oeIdle[DirAB]  = abOeN;
  assign oeIdle[DirBA]  = baOeN;

  for (genvar d = 0; d < NumDirs; d++) begin : gDir
    assign oeRise[d] = oeIdle[d] & ~oePrev[d];

    always_ff @(posedge clk) begin
      if (rst) begin
        oePrev[d] <= 1'b1;
        full[d]   <= 1'b0;
      end else begin
        oePrev[d] <= oeIdle[d];
        if (loadReq[d]) begin
          full[d] <= 1'b1;
        end else if (oeRise[d]) begin
          full[d] <= 1'b0;
        end
      end
    end

    assert_flag_set_R2 : assert property (@(posedge clk) disable iff (rst)
      loadReq[d] |=> full[d]);

    assert_flag_clear_R3 : assert property (@(posedge clk) disable iff (rst)
      (oeRise[d] && !loadReq[d]) |=> !full[d]);

    assert_flag_steady_R3 : assert property (@(posedge clk) disable iff (rst)
      (!loadReq[d] && !oeRise[d]) |=> $stable(full[d]));

    assert_set_wins_R9 : assert property (@(posedge clk) disable iff (rst)
      (loadReq[d] && oeRise[d]) |=> full[d]);
  end

  always_comb begin
    strobes.abLoad  = loadReq[DirAB];
    strobes.baLoad  = loadReq[DirBA];
    strobes.abDrive = ~oeIdle[DirAB];
    strobes.baDrive = ~oeIdle[DirBA];
  end

  assign abFull = full[DirAB];
  assign baFull = full[DirBA];
endmodule

// File: rtl/xcvr_dpath.sv
module xcvr_dpath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bParIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn,
  output logic             parOut,
  output logic             parOutEn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic             parErrN
);
  localparam logic [WIDTH-1:0] ZeroWord = '0;

  logic [WIDTH-1:0] abReg;
  logic [WIDTH-1:0] baReg;
  logic             baParReg;
  logic             abEvenOnes;
  logic             baOddOnes;

  always_ff @(posedge clk) begin
    if (rst) begin
      abReg <= ZeroWord;
    end else if (strobes.abLoad) begin
      abReg <= aIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baReg    <= ZeroWord;
      baParReg <= 1'b0;
    end else if (strobes.baLoad) begin
      baReg    <= bIn;
      baParReg <= bParIn;
    end
  end

  assign abEvenOnes = ~(^abReg);
  assign baOddOnes  = (^baReg) ^ baParReg;

  always_comb begin
    bOutEn   = strobes.abDrive;
    bOut     = strobes.abDrive ? abReg : ZeroWord;
    parOutEn = strobes.abDrive;
    parOut   = strobes.abDrive & abEvenOnes;
    aOutEn   = strobes.baDrive;
    aOut     = strobes.baDrive ? baReg : ZeroWord;
    parErrN  = strobes.baDrive ? baOddOnes : 1'b1;
  end

  assert_ab_hold_R1 : assert property (@(posedge clk) disable iff (rst)
    !strobes.abLoad |=> $stable(abReg));

  assert_ba_hold_R1 : assert property (@(posedge clk) disable iff (rst)
    !strobes.baLoad |=> $stable(baReg));

  assert_ab_capture_R1 : assert property (@(posedge clk) disable iff (rst)
    strobes.abLoad |=> (abReg == $past(aIn)));

  assert_par_capture_R6 : assert property (@(posedge clk) disable iff (rst)
    strobes.baLoad |=> (baParReg == $past(bParIn)));

  assert_quiet_b_R4 : assert property (@(posedge clk) disable iff (rst)
    !bOutEn |-> (bOut == ZeroWord && !parOut));

  assert_err_idle_R8 : assert property (@(posedge clk) disable iff (rst)
    !aOutEn |-> parErrN);
endmodule

// File: rtl/xcvr_handshake_port.sv
module xcvr_handshake_port
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bParIn,
  input  logic             abLoadN,
  input  logic             baLoadN,
  input  logic             abOeN,
  input  logic             baOeN,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn,
  output logic             parOut,
  output logic             parOutEn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic             parErrN,
  output logic             abFull,
  output logic             baFull
);
  xcvrStrobes_t strobes;

  xcvr_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .abLoadN (abLoadN),
    .baLoadN (baLoadN),
    .abOeN   (abOeN),
    .baOeN   (baOeN),
    .strobes (strobes),
    .abFull  (abFull),
    .baFull  (baFull)
  );

  xcvr_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .aIn      (aIn),
    .bIn      (bIn),
    .bParIn   (bParIn),
    .bOut     (bOut),
    .bOutEn   (bOutEn),
    .parOut   (parOut),
    .parOutEn (parOutEn),
    .aOut     (aOut),
    .aOutEn   (aOutEn),
    .parErrN  (parErrN)
  );
endmodule

// File: tb/tb_xcvr_handshake_port.sv
`timescale 1ns/1ps
module tb_xcvr_handshake_port;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] aIn, bIn;
  logic       bParIn, abLoadN, baLoadN, abOeN, baOeN;
  logic [7:0] bOut, aOut;
  logic       bOutEn, parOut, parOutEn, aOutEn, parErrN, abFull, baFull;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_handshake_port dut (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .bParIn(bParIn),
    .abLoadN(abLoadN), .baLoadN(baLoadN), .abOeN(abOeN), .baOeN(baOeN),
    .bOut(bOut), .bOutEn(bOutEn), .parOut(parOut), .parOutEn(parOutEn),
    .aOut(aOut), .aOutEn(aOutEn), .parErrN(parErrN),
    .abFull(abFull), .baFull(baFull)
  );

  function automatic int onesOf(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic loadAB(input logic [7:0] v);
    aIn = v; abLoadN = 1'b0; tick(); abLoadN = 1'b1; #1;
  endtask

  task automatic loadBA(input logic [7:0] v, input logic p);
    bIn = v; bParIn = p; baLoadN = 1'b0; tick(); baLoadN = 1'b1; #1;
  endtask

  task automatic testReset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; #1;
    check("R10 abFull after reset", abFull, 0);
    check("R10 baFull after reset", baFull, 0);
    abOeN = 1'b0; baOeN = 1'b0; #1;
    check("R10 forward byte zero", bOut, 8'h00);
    check("R10 return byte zero", aOut, 8'h00);
    check("R10 stored parity zero -> even -> error", parErrN, 0);
    tick(); abOeN = 1'b1; baOeN = 1'b1; tick(); #1;
  endtask

  task automatic testLoadHold();
    loadAB(8'hA5);
    check("R2 abFull set by load", abFull, 1);
    aIn = 8'h3C; tick(); tick(); abOeN = 1'b0; #1;
    check("R1 hold ignores aIn while strobe high", bOut, 8'hA5);
    check("R4 bOutEn when enabled", bOutEn, 1);
    abOeN = 1'b1; #1;
    check("R4 bOutEn off when idle", bOutEn, 0);
    check("R4 bOut zero when idle", bOut, 8'h00);
    check("R5 parOutEn off when idle", parOutEn, 0);
    tick(); #1;
    loadBA(8'h5A, 1'b1);
    check("R2 baFull set by load", baFull, 1);
    baOeN = 1'b0; #1;
    check("R1 return register captured", aOut, 8'h5A);
    check("R4 aOutEn when enabled", aOutEn, 1);
    baOeN = 1'b1; #1;
    check("R4 aOut zero when idle", aOut, 8'h00);
    tick(); #1;
  endtask

  task automatic testParityGen();
    logic [7:0] pats [5] = '{8'h00, 8'h01, 8'hFF, 8'h7F, 8'h81};
    for (int i = 0; i < 5; i++) begin
      loadAB(pats[i]);
      abOeN = 1'b0; #1;
      check("R5 parOutEn", parOutEn, 1);
      check("R5 parity value", parOut, (onesOf({1'b0, pats[i]}) % 2 == 0) ? 1 : 0);
      tick(); abOeN = 1'b1; tick(); #1;
    end
  endtask

  task automatic testParityCheck();
    logic [7:0] d [5] = '{8'h01, 8'h03, 8'h00, 8'h00, 8'hFF};
    logic       p [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 5; i++) begin
      loadBA(d[i], p[i]);
      check("R8 error high while A side idle", parErrN, 1);
      bParIn = ~p[i];
      baOeN = 1'b0; #1;
      check("R7/R6 check uses stored parity", parErrN,
            (onesOf({p[i], d[i]}) % 2 == 1) ? 1 : 0);
      tick(); baOeN = 1'b1; tick(); #1;
    end
  endtask

  task automatic testClear();
    loadAB(8'h11);
    abOeN = 1'b0; tick(); tick(); #1;
    check("R3 flag kept while enable held low", abFull, 1);
    abOeN = 1'b1; #1;
    check("R3 flag not yet cleared before edge", abFull, 1);
    tick(); #1;
    check("R3 flag cleared after release", abFull, 0);
    tick(); tick(); #1;
    check("R3 flag stays clear while idle", abFull, 0);
    loadBA(8'h22, 1'b0);
    baOeN = 1'b0; tick(); baOeN = 1'b1; tick(); #1;
    check("R3 return flag cleared after release", baFull, 0);
  endtask

  task automatic testSetWins();
    loadAB(8'h40);
    abOeN = 1'b0; tick();
    abOeN = 1'b1; aIn = 8'h99; abLoadN = 1'b0; tick(); abLoadN = 1'b1; #1;
    check("R9 forward flag set wins", abFull, 1);
    abOeN = 1'b0; #1;
    check("R9 forward data is new byte", bOut, 8'h99);
    tick(); abOeN = 1'b1; tick(); #1;
    check("R3 forward flag clears after later release", abFull, 0);
    loadBA(8'h10, 1'b0);
    baOeN = 1'b0; tick();
    baOeN = 1'b1; bIn = 8'h77; bParIn = 1'b0; baLoadN = 1'b0; tick(); baLoadN = 1'b1; #1;
    check("R9 return flag set wins", baFull, 1);
    tick(); #1;
  endtask

  initial begin
    rst = 1'b1; aIn = '0; bIn = '0; bParIn = 1'b0;
    abLoadN = 1'b1; baLoadN = 1'b1; abOeN = 1'b1; baOeN = 1'b1;
    tick();
    testReset();
    testLoadHold();
    testParityGen();
    testParityCheck();
    testClear();
    testSetWins();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule